// File: doc/BRIEF.md
# Burst Transfer Target for a Shared Parallel Bus

This block is a synchronous bus target for a multiplexed address/data bus that uses a burst protocol in the PCI style. All bus inputs are sampled on the rising clock edge. The target notices when a transaction starts and latches its command and starting address. If the access is one it serves, it claims it and then moves a burst of any length between the bus and a small array of word registers. The address advances by one word after each completed word. Both sides can stall: the initiator through its ready line, and the target through a fixed number of initial wait states.

The shared lines are brought out as separate value and output-enable pins, so the block can sit behind pad or bus-fabric logic that resolves the tri-state. Commands outside the two memory commands, and addresses outside the window, are ignored. The block stays silent until the bus goes idle again.

Top module: `pcit_target`

## Requirements
- R1: While `rstN` is low, `trdyOe`, `devselOe` and `adOutEn` are 0 and `trdyN`, `devselN` are 1. After reset, all register words read as zero.
- R2: An address phase is a rising edge with `frameN` low while the target is idle. The target claims the access only if `cbeN` is 4'b0110 (memory read) or 4'b0111 (memory write) and `BASE_ADDR <= adIn < BASE_ADDR + 4*WORDS`. From the next cycle on, `devselOe`=1 and `devselN`=0 until the release cycle.
- R3: Take the address phase as cycle 0. `trdyN` first goes low in cycle 1+`INIT_WAIT` for writes and in cycle 1+max(`INIT_WAIT`,1) for reads. It stays low until the last transfer.
- R4: `adOutEn` is 0 in cycle 1, which is the turnaround cycle. For reads it is 1 from cycle 2 through the cycle of the last transfer. For writes it is never 1.
- R5: A word moves only on a rising edge where both `irdyN` and `trdyN` are low. On a read, `adOut` carries the addressed word. On a write, the word is stored. Edges with `irdyN` low while `trdyN` is high move nothing.
- R6: The first word has index (start address - `BASE_ADDR`)/4. The index advances by one per moved word and wraps from `WORDS`-1 to 0.
- R7: During write data phases, bit i of `cbeN` is an active-low byte enable for `adIn[8i+7:8i]`. Disabled lanes keep their stored value.
- R8: A transfer with `frameN` high is the last one. In the next cycle the target drives `trdyN` and `devselN` high with both enables at 1 and `adOutEn` at 0. If `frameN` is still high then, all enables are 0 in the cycle after.
- R9: A new address phase presented in the release cycle is accepted and served like one presented while idle.
- R10: An access that is not claimed keeps all three enables at 0 through its data phases. This holds even when those phases carry in-window values with command-like `cbeN`. The target re-arms only after an edge where `frameN` and `irdyN` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Transaction framing, active low |
| irdyN | input | 1 | Initiator ready, active low |
| cbeN | input | 4 | Command in the address phase, active-low byte enables in data phases |
| adIn | input | 32 | Address/data lines as seen by the target |
| adOut | output | 32 | Read data toward the address/data lines |
| adOutEn | output | 1 | Enable for driving `adOut` onto the shared lines |
| trdyN | output | 1 | Target ready value, active low |
| trdyOe | output | 1 | Enable for driving `trdyN` |
| devselN | output | 1 | Claim indication value, active low |
| devselOe | output | 1 | Enable for driving `devselN` |

## Verification
The release of one transaction and the address phase of the next can fall in the same cycle. The bench provokes this by chaining bursts, placing a new address and command on the bus in the release cycle of the previous burst, in both write-to-read and read-to-write orders. It judges the outcome in two ways. The release cycle must still show both control lines driven high, and the cycle after must show the claim again. The chained burst must also start at its own index, which is confirmed by later read-backs of the whole array against a model of the register array kept in the bench.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

  localparam int AD_W  = 32;
  localparam int LANES = AD_W / 8;

  localparam logic [LANES-1:0] CMD_MEM_RD = 4'b0110;
  localparam logic [LANES-1:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_REL,
    ST_SKIP
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch start index and direction
    logic xfer;     // one word moves on this edge
  } dpStrobes_t;

endpackage

// File: rtl/pcit_datapath.sv
module pcit_datapath
  import pcit_pkg::*;
#(
  parameter int              WORDS     = 8,
  parameter logic [AD_W-1:0] BASE_ADDR = 32'h0000_4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [AD_W-1:0]  adIn,
  input  logic [LANES-1:0] cbeN,
  output logic             addrHit,
  output logic             cmdRead,
  output logic             cmdWrite,
  output logic             writeMode,
  output logic [AD_W-1:0]  adOut
);

  localparam int              IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [AD_W-1:0] WIN_BYTES = AD_W'(WORDS * LANES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [AD_W-1:0]  offset;
  logic [IDX_W-1:0] wordIdx;
  logic [AD_W-1:0]  rowData [WORDS];

  // address window and command decode
  always_comb begin
    offset   = adIn - BASE_ADDR;
    addrHit  = (adIn >= BASE_ADDR) && (offset < WIN_BYTES);
    cmdRead  = (cbeN == CMD_MEM_RD);
    cmdWrite = (cbeN == CMD_MEM_WR);
  end

  // word index and direction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx   <= '0;
      writeMode <= 1'b0;
    end else if (strobes.capture) begin
      wordIdx   <= offset[IDX_W+1:2];
      writeMode <= cmdWrite;
    end else if (strobes.xfer) begin
      wordIdx   <= (wordIdx == LAST_IDX) ? '0 : wordIdx + 1'b1;
    end
  end

  // register array, one row per word, byte-lane enables
  for (genvar w = 0; w < WORDS; w++) begin : g_row
    logic            rowSel;
    logic [AD_W-1:0] rowQ;

    assign rowSel = strobes.xfer && writeMode && (wordIdx == IDX_W'(w));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rowQ <= '0;
      end else if (rowSel) begin
        for (int b = 0; b < LANES; b++) begin
          if (!cbeN[b]) rowQ[b*8 +: 8] <= adIn[b*8 +: 8];
        end
      end
    end

    assign rowData[w] = rowQ;
  end

  assign adOut = rowData[wordIdx];

endmodule

// File: rtl/pcit_ctrl.sv
module pcit_ctrl
  import pcit_pkg::*;
#(
  parameter int INIT_WAIT = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       addrHit,
  input  logic       cmdRead,
  input  logic       cmdWrite,
  input  logic       writeMode,
  output dpStrobes_t strobes,
  output logic       trdyN,
  output logic       trdyOe,
  output logic       devselN,
  output logic       devselOe,
  output logic       adOutEn
);

  // reads need at least one cycle for the data-line turnaround
  localparam int RD_WAIT = (INIT_WAIT < 1) ? 1 : INIT_WAIT;
  localparam int CNT_W   = $clog2(RD_WAIT + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(INIT_WAIT);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  busState_e        state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitNext, loadVal;
  logic             adDrive, adDriveNext;
  logic             addrPhase, claim, xferNow, lastXfer, engaged;

  always_comb begin
    addrPhase = ((state == ST_IDLE) || (state == ST_REL)) && !frameN;
    claim     = addrPhase && addrHit && (cmdRead || cmdWrite);
    loadVal   = cmdWrite ? WR_LOAD : RD_LOAD;
    xferNow   = (state == ST_DATA) && !irdyN;
    lastXfer  = xferNow && frameN;
  end

  always_comb begin
    stateNext   = state;
    waitNext    = waitCnt;
    adDriveNext = 1'b0;
    case (state)
      ST_IDLE, ST_REL: begin
        if (addrPhase) begin
          if (claim) begin
            waitNext  = loadVal;
            stateNext = (loadVal == '0) ? ST_DATA : ST_WAIT;
          end else begin
            stateNext = ST_SKIP;
          end
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_WAIT: begin
        adDriveNext = !writeMode;
        waitNext    = waitCnt - ONE;
        if (waitCnt == ONE) stateNext = ST_DATA;
      end
      ST_DATA: begin
        adDriveNext = adDrive && !lastXfer;
        if (lastXfer) stateNext = ST_REL;
      end
      ST_SKIP: begin
        if (frameN && irdyN) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      adDrive <= 1'b0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitNext;
      adDrive <= adDriveNext;
    end
  end

  always_comb begin
    engaged         = (state == ST_WAIT) || (state == ST_DATA) || (state == ST_REL);
    strobes.capture = claim;
    strobes.xfer    = xferNow;
    devselOe        = engaged;
    devselN         = !((state == ST_WAIT) || (state == ST_DATA));
    trdyOe          = engaged;
    trdyN           = (state != ST_DATA);
    adOutEn         = adDrive;
  end

endmodule

// File: rtl/pcit_target.sv
module pcit_target
  import pcit_pkg::*;
#(
  parameter int              WORDS     = 8,
  parameter logic [AD_W-1:0] BASE_ADDR = 32'h0000_4000,
  parameter int              INIT_WAIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [LANES-1:0] cbeN,
  input  logic [AD_W-1:0]  adIn,
  output logic [AD_W-1:0]  adOut,
  output logic             adOutEn,
  output logic             trdyN,
  output logic             trdyOe,
  output logic             devselN,
  output logic             devselOe
);

  dpStrobes_t strobes;
  logic       addrHit, cmdRead, cmdWrite, writeMode;

  pcit_ctrl #(
    .INIT_WAIT(INIT_WAIT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .addrHit  (addrHit),
    .cmdRead  (cmdRead),
    .cmdWrite (cmdWrite),
    .writeMode(writeMode),
    .strobes  (strobes),
    .trdyN    (trdyN),
    .trdyOe   (trdyOe),
    .devselN  (devselN),
    .devselOe (devselOe),
    .adOutEn  (adOutEn)
  );

  pcit_datapath #(
    .WORDS    (WORDS),
    .BASE_ADDR(BASE_ADDR)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .adIn     (adIn),
    .cbeN     (cbeN),
    .addrHit  (addrHit),
    .cmdRead  (cmdRead),
    .cmdWrite (cmdWrite),
    .writeMode(writeMode),
    .adOut    (adOut)
  );

endmodule

// File: rtl/pcit_target_chk.sv
module pcit_target_chk (
  input logic clk,
  input logic rstN,
  input logic frameN,
  input logic irdyN,
  input logic adOutEn,
  input logic trdyN,
  input logic trdyOe,
  input logic devselN,
  input logic devselOe
);

  // R1: nothing driven while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rstN |-> (!trdyOe && !devselOe && !adOutEn));

  // R3: ready is only offered inside a claimed access
  a_r3_ready_inside_claim: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOe && !trdyN) |-> (devselOe && !devselN));

  // R4: data lines driven only while claimed
  a_r4_drive_needs_claim: assert property (@(posedge clk) disable iff (!rstN)
    adOutEn |-> (devselOe && !devselN && trdyOe));

  // R4: turnaround cycle after a fresh address phase
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(frameN) && !devselOe) |=> !adOutEn);

  // R5: target keeps ready while the initiator stalls
  a_r5_hold_ready: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOe && !trdyN && irdyN) |=> (trdyOe && !trdyN));

  // R8: last transfer leads to a driven-high release cycle
  a_r8_release_high: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOe && !trdyN && !irdyN && frameN) |=>
      (trdyOe && trdyN && devselOe && devselN && !adOutEn));

  // R8: release cycle with idle bus leads to floating lines
  a_r8_float_after: assert property (@(posedge clk) disable iff (!rstN)
    (devselOe && devselN && frameN) |=> (!devselOe && !trdyOe));

endmodule

bind pcit_target pcit_target_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .frameN  (frameN),
  .irdyN   (irdyN),
  .adOutEn (adOutEn),
  .trdyN   (trdyN),
  .trdyOe  (trdyOe),
  .devselN (devselN),
  .devselOe(devselOe)
);

// File: tb/pcit_target_tb_top.sv
module pcit_target_tb_top;

  localparam int          WORDS   = 8;
  localparam logic [31:0] BASE    = 32'h0000_4000;
  localparam int          TB_WAIT = 2;

  logic        clk, rstN, frameN, irdyN;
  logic [3:0]  cbeN;
  logic [31:0] adIn, adOut;
  logic        adOutEn, trdyN, trdyOe, devselN, devselOe;

  int checks = 0;
  int fails  = 0;
  logic [31:0] shadow [WORDS];

  pcit_target #(
    .WORDS    (WORDS),
    .BASE_ADDR(BASE),
    .INIT_WAIT(TB_WAIT)
  ) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .irdyN   (irdyN),
    .cbeN    (cbeN),
    .adIn    (adIn),
    .adOut   (adOut),
    .adOutEn (adOutEn),
    .trdyN   (trdyN),
    .trdyOe  (trdyOe),
    .devselN (devselN),
    .devselOe(devselOe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one burst; cycle 0 is the address phase
  task automatic burst(bit wr, int startIdx, int len, int stall, logic [3:0] be,
                       bit chainIn, bit chainOut, bit nWr, int nIdx);
    int cycle, done, idx, firstT;
    bit eligible, xf;
    logic [31:0] d;
    firstT = 1 + (wr ? TB_WAIT : ((TB_WAIT < 1) ? 1 : TB_WAIT));
    if (!chainIn) begin
      frameN = 1'b0; irdyN = 1'b1;
      adIn = BASE + 32'(startIdx * 4);
      cbeN = wr ? 4'b0111 : 4'b0110;
      @(negedge clk);
    end
    cycle = 1; done = 0; idx = startIdx;
    while (done < len) begin
      eligible = (cycle >= firstT);
      chk("R2", "claim", 32'({devselOe, devselN}), 32'b10);
      chk("R3", "trdyN", 32'(trdyN), 32'(!eligible));
      chk("R4", "adOutEn", 32'(adOutEn), 32'(!wr && cycle >= 2));
      irdyN = (stall != 0) && (cycle % stall == 0);
      xf = eligible && !irdyN;
      d = 32'h5A3C_0F96 ^ {8'(startIdx), 8'(len), 8'(done), 8'(cycle)};
      if (wr) begin
        adIn = d; cbeN = be;
      end else begin
        adIn = 32'h0; cbeN = 4'b0000;
      end
      if (xf && !wr) chk("R5 R6", "read word", adOut, shadow[idx]);
      frameN = xf && (done == len - 1);
      if (xf) begin
        if (wr) for (int b = 0; b < 4; b++) if (!be[b]) shadow[idx][b*8 +: 8] = d[b*8 +: 8];
        done++;
        idx = (idx + 1) % WORDS;
      end
      @(negedge clk);
      cycle++;
    end
    chk("R8", "release", 32'({trdyOe, trdyN, devselOe, devselN, adOutEn}), 32'b11110);
    irdyN = 1'b1;
    if (chainOut) begin
      frameN = 1'b0;
      adIn = BASE + 32'(nIdx * 4);
      cbeN = nWr ? 4'b0111 : 4'b0110;
      @(negedge clk);
    end else begin
      frameN = 1'b1;
      @(negedge clk);
      chk("R8", "float", 32'({trdyOe, devselOe, adOutEn}), 32'b000);
    end
  endtask

  // access the target must not claim
  task automatic ignored(logic [3:0] cmd, logic [31:0] addr);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd;
    @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      chk("R10", "silent", 32'({devselOe, trdyOe, adOutEn}), 32'b000);
      irdyN = 1'b0;
      frameN = (k == 4);
      adIn = BASE;          // in-window value during data phases
      cbeN = 4'b0111;       // looks like a write command
      @(negedge clk);
    end
    chk("R10", "silent end", 32'({devselOe, trdyOe, adOutEn}), 32'b000);
    irdyN = 1'b1; frameN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readAll();
    burst(1'b0, 0, WORDS, 0, 4'b0000, 1'b0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    int stalls [3];
    int lens [4];
    stalls = '{0, 2, 3};
    lens   = '{1, 2, 5, 9};
    for (int i = 0; i < WORDS; i++) shadow[i] = 32'h0;
    rstN = 1'b1; frameN = 1'b1; irdyN = 1'b1; cbeN = 4'h0; adIn = 32'h0;
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", 32'({trdyOe, devselOe, adOutEn, trdyN, devselN}), 32'b00011);
    rstN = 1'b1;
    @(negedge clk);

    readAll();  // R1: array cleared
    burst(1'b1, 0, WORDS, 0, 4'b0000, 1'b0, 1'b0, 1'b0, 0);
    readAll();

    // sweep: start index, length, stall pattern, byte enables (R6 R7)
    for (int s = 0; s < WORDS; s++) begin
      for (int li = 0; li < 4; li++) begin
        burst(1'b1, s, lens[li], stalls[(s + li) % 3], 4'((s * 3 + lens[li]) % 16),
              1'b0, 1'b0, 1'b0, 0);
        burst(1'b0, s, lens[li], stalls[(s + li + 1) % 3], 4'b0000,
              1'b0, 1'b0, 1'b0, 0);
      end
    end
    readAll();

    // R9: address phase in the release cycle, both orders
    burst(1'b1, 2, 3, 0, 4'b0000, 1'b0, 1'b1, 1'b0, 2);
    burst(1'b0, 2, 3, 2, 4'b0000, 1'b1, 1'b1, 1'b1, 7);
    burst(1'b1, 7, 2, 3, 4'b0101, 1'b1, 1'b0, 1'b0, 0);
    readAll();

    // R10 and R2: unclaimed accesses leave the array untouched
    ignored(4'b0010, BASE);
    ignored(4'b0111, BASE - 32'd4);
    ignored(4'b0111, BASE + 32'(WORDS * 4));
    ignored(4'b0110, BASE + 32'(WORDS * 4) + 32'd8);
    ignored(4'b0011, BASE + 32'd4);
    readAll();

    summary();
    $finish;
  end

endmodule